// File: doc/BRIEF.md
# Embedded Processor Boot Sequencer

This block brings an embedded microprocessor from an unloaded state to running code. A one-cycle start request makes it freeze the processor (stall plus stall-override). It then asks an external section loader for two loads in a fixed order, data memory first and instruction memory second, using a start/done handshake for each. Next it gives a one-cycle request to clear the soft-reset and low-power controls. It then holds the processor reset together with stall and override for a timed window. Finally it drops stall and reset and leaves only the override set, which lets the processor run.

If the loader reports a failure on either section, the sequence stops at once. The processor is left frozen and an error pulse is given. The length of the reset window is given in nanoseconds and turned into clock cycles from the clock-frequency parameter, rounding up. A start request that arrives while a sequence is already in progress has no effect.

Top module: `boot_seq`

## Requirements
- R1: A start request seen while idle sets `stall_o` and `stall_ovr_o` in the next cycle, with `cpu_rst_o` low. Both stay set through every load request.
- R2: Exactly one load request is made per section. `ld_start_o` is a one-cycle pulse, with `ld_sel_o`=0 (data memory) for the first request and `ld_sel_o`=1 (instruction memory) for the second. The data request comes two cycles after the start is taken. The instruction request comes one cycle after the data load's `ld_done_i`, and only if that done had `ld_err_i` low.
- R3: When `ld_done_i` comes with `ld_err_i` high, the sequence aborts. `err_o` pulses in the next cycle, no further load request is made, `stall_o` and `stall_ovr_o` stay high, and `cpu_rst_o` stays low.
- R4: One cycle after a successful instruction load's `ld_done_i`, `ctl_clr_o` pulses for one cycle. `cpu_rst_o` rises in the cycle after that pulse.
- R5: `cpu_rst_o` stays high for exactly ceil(CLK_HZ × HOLD_NS / 10^9) cycles, with `stall_o` and `stall_ovr_o` high the whole time.
- R6: In the cycle after the reset window ends, `stall_o` and `cpu_rst_o` are low and `stall_ovr_o` is high. `done_o` pulses in that same cycle, and this control state is kept until the next start.
- R7: `start_i` has no effect while a sequence is in progress.
- R8: After reset all outputs are low. `done_o` and `err_o` are single-cycle pulses.
- R9: `ld_done_i` and `ld_err_i` are ignored except in the cycles spent waiting for a requested load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a boot sequence (taken only while idle) |
| ld_done_i | input | 1 | Loader finished the requested section |
| ld_err_i | input | 1 | Loader check failed; qualified by ld_done_i |
| ld_start_o | output | 1 | One-cycle request to load a section |
| ld_sel_o | output | 1 | Section to load: 0 data memory, 1 instruction memory |
| ctl_clr_o | output | 1 | One-cycle request to clear soft-reset and low-power controls |
| stall_o | output | 1 | Processor stall |
| stall_ovr_o | output | 1 | Stall override |
| cpu_rst_o | output | 1 | Processor reset |
| done_o | output | 1 | One-cycle pulse: processor released |
| err_o | output | 1 | One-cycle pulse: a section load failed |

## Verification
The sequencer is run through four kinds of runs. There are clean boots with short and with single-cycle loader latency, which show whether the load order and the handshake timing are right. There is a failure on the data section and a failure on the instruction section, which show whether the abort leaves the processor frozen and whether any later step leaks through. Stray start requests and stray loader responses are added while idle, while waiting and during the reset window, to separate a design that ignores them from one that reacts. The bench sets an odd reset window so that rounding up can be told apart from truncation.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic [3:0] {
    S_IDLE  = 4'd0,
    S_STALL = 4'd1,
    S_DREQ  = 4'd2,
    S_DWAIT = 4'd3,
    S_IREQ  = 4'd4,
    S_IWAIT = 4'd5,
    S_CLR   = 4'd6,
    S_HOLD  = 4'd7
  } bsq_state_e;

  // Reset window in cycles, rounded up; never below one.
  function automatic int unsigned hold_cycles(input longint clk_hz, input longint hold_ns);
    longint c;
    c = (clk_hz * hold_ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/bsq_rst_sync.sv
module bsq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bsq_hold_timer.sv
module bsq_hold_timer #(
  parameter int unsigned HOLD_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam int unsigned CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [CW-1:0] LAST_VAL = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = run_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)                cnt_d = '0;
    else if (cnt_q != LAST_VAL) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = run_i && (cnt_q == LAST_VAL);

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_VAL);
  p_idle_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/bsq_ctl_fsm.sv
module bsq_ctl_fsm
  import bsq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ld_done_i,
  input  logic ld_err_i,
  input  logic hold_last_i,
  output logic hold_run_o,
  output logic ld_start_o,
  output logic ld_sel_o,
  output logic ctl_clr_o,
  output logic stall_o,
  output logic stall_ovr_o,
  output logic cpu_rst_o,
  output logic done_o,
  output logic err_o
);
  bsq_state_e state_q, state_d;
  logic stall_q, stall_d, ovr_q, ovr_d, prst_q, prst_d;
  logic done_q, done_d, err_q, err_d;

  always_comb begin
    state_d = state_q;
    stall_d = stall_q;
    ovr_d   = ovr_q;
    prst_d  = prst_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_STALL;
        stall_d = 1'b1;
        ovr_d   = 1'b1;
        prst_d  = 1'b0;
      end
      S_STALL: state_d = S_DREQ;
      S_DREQ:  state_d = S_DWAIT;
      S_DWAIT: if (ld_done_i) begin
        if (ld_err_i) begin state_d = S_IDLE; err_d = 1'b1; end
        else                state_d = S_IREQ;
      end
      S_IREQ:  state_d = S_IWAIT;
      S_IWAIT: if (ld_done_i) begin
        if (ld_err_i) begin state_d = S_IDLE; err_d = 1'b1; end
        else                state_d = S_CLR;
      end
      S_CLR: begin
        state_d = S_HOLD;
        prst_d  = 1'b1;
      end
      S_HOLD: if (hold_last_i) begin
        state_d = S_IDLE;
        prst_d  = 1'b0;
        stall_d = 1'b0;
        done_d  = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      stall_q <= 1'b0;
      ovr_q   <= 1'b0;
      prst_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stall_q <= stall_d;
      ovr_q   <= ovr_d;
      prst_q  <= prst_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign hold_run_o  = (state_q == S_HOLD);
  assign ld_start_o  = (state_q == S_DREQ) || (state_q == S_IREQ);
  assign ld_sel_o    = (state_q == S_IREQ) || (state_q == S_IWAIT);
  assign ctl_clr_o   = (state_q == S_CLR);
  assign stall_o     = stall_q;
  assign stall_ovr_o = ovr_q;
  assign cpu_rst_o   = prst_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  p_load_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_start_o |-> (stall_o && stall_ovr_o && !cpu_rst_o));
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_start_o |=> !ld_start_o);
  p_abort_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (stall_o && stall_ovr_o && !cpu_rst_o && !ld_start_o));
  p_clr_then_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr_o |=> cpu_rst_o);
  p_rst_guarded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_o |-> (stall_o && stall_ovr_o));
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (stall_ovr_o && !stall_o && !cpu_rst_o && $past(cpu_rst_o)));
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |=> !(done_o || err_o));
endmodule

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int unsigned CLK_HZ  = 200_000_000,
  parameter int unsigned HOLD_NS = 100_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ld_done_i,
  input  logic ld_err_i,
  output logic ld_start_o,
  output logic ld_sel_o,
  output logic ctl_clr_o,
  output logic stall_o,
  output logic stall_ovr_o,
  output logic cpu_rst_o,
  output logic done_o,
  output logic err_o
);
  localparam int unsigned HOLD_CYC = bsq_pkg::hold_cycles(longint'(CLK_HZ), longint'(HOLD_NS));

  logic rst_sync_n;
  logic hold_run, hold_last;

  bsq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bsq_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (hold_run),
    .last_o (hold_last)
  );

  bsq_ctl_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .ld_done_i   (ld_done_i),
    .ld_err_i    (ld_err_i),
    .hold_last_i (hold_last),
    .hold_run_o  (hold_run),
    .ld_start_o  (ld_start_o),
    .ld_sel_o    (ld_sel_o),
    .ctl_clr_o   (ctl_clr_o),
    .stall_o     (stall_o),
    .stall_ovr_o (stall_ovr_o),
    .cpu_rst_o   (cpu_rst_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );
endmodule

// File: tb/boot_seq_tb.sv
module boot_seq_tb;
  localparam int unsigned T_HZ  = 200_000_000;
  localparam int unsigned T_NS  = 1_003;
  // 200 MHz * 1003 ns = 200.6 cycles, rounded up
  localparam int EXP_HOLD = 201;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic ld_done_i, ld_err_i;
  logic ld_start_o, ld_sel_o, ctl_clr_o, stall_o, stall_ovr_o, cpu_rst_o, done_o, err_o;

  logic resp_done = 1'b0, resp_err = 1'b0, stray_done = 1'b0;
  assign ld_done_i = resp_done || stray_done;
  assign ld_err_i  = resp_err;

  always #2.5 clk = ~clk;

  boot_seq #(.CLK_HZ(T_HZ), .HOLD_NS(T_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .ld_done_i(ld_done_i), .ld_err_i(ld_err_i),
    .ld_start_o(ld_start_o), .ld_sel_o(ld_sel_o), .ctl_clr_o(ctl_clr_o),
    .stall_o(stall_o), .stall_ovr_o(stall_ovr_o), .cpu_rst_o(cpu_rst_o),
    .done_o(done_o), .err_o(err_o)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Loader responder: answers each request after lat cycles.
  int lat = 3;
  bit fail_data = 0, fail_instr = 0;
  int resp_cnt = -1;
  bit resp_sel = 0;
  int n_req = 0;
  always @(negedge clk) begin
    resp_done = 1'b0;
    resp_err  = 1'b0;
    if (ld_start_o) begin
      resp_cnt = lat;
      resp_sel = ld_sel_o;
      n_req++;
    end else if (resp_cnt > 0) begin
      resp_cnt--;
    end
    if (resp_cnt == 0) begin
      resp_done = 1'b1;
      resp_err  = resp_sel ? fail_instr : fail_data;
      resp_cnt  = -1;
    end
  end

  // Behavioural reference model
  int m_ph = 0;       // 0 idle, 1 freeze, 2 data req, 3 data wait, 4 instr req, 5 instr wait, 6 clear, 7 reset window
  int m_hold = 0;
  bit m_stall = 0, m_ovr = 0, m_rst = 0, m_done = 0, m_err = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_hold = 0;
      m_stall = 0; m_ovr = 0; m_rst = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (m_ph == 0) begin
        if (start_i) begin m_ph = 1; m_stall = 1; m_ovr = 1; m_rst = 0; end
      end else if (m_ph == 1 || m_ph == 2 || m_ph == 4) begin
        m_ph = m_ph + 1;
      end else if (m_ph == 3 || m_ph == 5) begin
        if (ld_done_i) begin
          if (ld_err_i) begin m_ph = 0; m_err = 1; end
          else m_ph = (m_ph == 3) ? 4 : 6;
        end
      end else if (m_ph == 6) begin
        m_ph = 7; m_rst = 1; m_hold = 0;
      end else begin
        m_hold++;
        if (m_hold == EXP_HOLD) begin m_ph = 0; m_rst = 0; m_stall = 0; m_done = 1; end
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  bit cmp_en = 0;
  int rst_run = 0;
  int last_rst_run = 0;
  always @(negedge clk) begin
    if (cmp_en) begin
      bit e_start;
      e_start = (m_ph == 2 || m_ph == 4);
      check("R1", "stall_o", stall_o, m_stall);
      check("R1", "stall_ovr_o", stall_ovr_o, m_ovr);
      check("R2", "ld_start_o", ld_start_o, e_start);
      if (e_start) check("R2", "ld_sel_o", ld_sel_o, (m_ph == 4));
      check("R4", "ctl_clr_o", ctl_clr_o, (m_ph == 6));
      check("R5", "cpu_rst_o", cpu_rst_o, m_rst);
      check("R6", "done_o", done_o, m_done);
      check("R3", "err_o", err_o, m_err);
      if (cpu_rst_o) rst_run++;
      else begin
        if (rst_run != 0) last_rst_run = rst_run;
        rst_run = 0;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic stray_resp();
    @(negedge clk); stray_done = 1'b1;
    @(negedge clk); stray_done = 1'b0;
  endtask

  task automatic wait_end(input int limit);
    int k;
    k = 0;
    while (!done_o && !err_o && k < limit) begin @(negedge clk); k++; end
  endtask

  initial begin
    fork
      begin
        cyc(3);
        // R8: reset state
        check("R8", "outputs in reset", {ld_start_o, ctl_clr_o, stall_o, stall_ovr_o, cpu_rst_o, done_o, err_o}, 0);
        @(negedge clk); rst_n = 1'b1;
        cyc(4);
        cmp_en = 1;

        // R9: stray loader response while idle
        stray_resp();
        cyc(2);
        check("R9", "no freeze after stray done", stall_o, 0);

        // Clean boot with stray start and stray done inside the run (R7, R9)
        lat = 3; n_req = 0;
        pulse_start();
        cyc(3);
        pulse_start();              // busy: ignored (R7)
        wait (cpu_rst_o == 1'b1);
        cyc(20);
        stray_resp();               // in reset window: ignored (R9)
        pulse_start();              // busy: ignored (R7)
        wait_end(1000);
        check("R6", "done pulse seen", done_o, 1);
        cyc(1);
        check("R8", "done one cycle", done_o, 0);
        check("R6", "override kept", stall_ovr_o, 1);
        check("R6", "stall released", stall_o, 0);
        check("R5", "reset window length", last_rst_run, EXP_HOLD);
        check("R2", "two load requests", n_req, 2);
        cyc(5);

        // Failure on data section (R3)
        fail_data = 1; n_req = 0;
        pulse_start();
        wait_end(1000);
        check("R3", "err pulse on data fail", err_o, 1);
        cyc(1);
        check("R8", "err one cycle", err_o, 0);
        cyc(10);
        check("R3", "only one request after data fail", n_req, 1);
        check("R3", "left frozen", stall_o, 1);
        check("R3", "no reset after abort", cpu_rst_o, 0);
        fail_data = 0;

        // Failure on instruction section (R3)
        fail_instr = 1; n_req = 0; lat = 2;
        pulse_start();
        wait_end(1000);
        check("R3", "err pulse on instr fail", err_o, 1);
        cyc(10);
        check("R3", "two requests before abort", n_req, 2);
        check("R3", "frozen after instr fail", stall_o && stall_ovr_o, 1);
        fail_instr = 0;

        // Clean boot with single-cycle loader latency
        lat = 1; n_req = 0;
        pulse_start();
        wait_end(1000);
        check("R6", "done after fast loads", done_o, 1);
        cyc(3);
        check("R5", "reset window length fast", last_rst_run, EXP_HOLD);
        check("R2", "two requests fast", n_req, 2);
        cyc(5);
      end
      begin
        cyc(20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected finished");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule